// File: doc/BRIEF.md
# Multiframe Clock Reference Pulse and Alignment Counter

This block lives in the link clock domain of a serial converter receiver. It does two jobs. First, it generates a periodic reference pulse whose period is exactly one multiframe. Second, it keeps a local multiframe counter that a received reference pulse can restart, so that the counter's wrap point lines up with the pulse.

The multiframe length in link clocks is derived from three parameters: the octets per frame, the frames per multiframe, and the octets carried per link clock. Each rising edge of the incoming reference is registered once and acted on once.

There are two capture modes:
- **Single-shot:** only the first edge after reset, or after an arm request, restarts the counter.
- **Continuous:** every edge restarts the counter. Once the counter has been aligned, any edge that arrives away from the natural wrap point raises a sticky alignment error.

Looping the generated pulse back to the reference input gives an aligned system that never reports an error.

Top module: `mfclk_sysref_align`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `mf_count`=0, `mf_boundary`=1, `sysref_out`=0, `captured`=0 and `align_err`=0.
- R2: The multiframe length is MF_CLKS = FRAME_OCTETS*FRAMES_PER_MF/OCTETS_PER_CLK (16 at defaults). Without a restart, `mf_count` steps by one per clock and wraps from MF_CLKS-1 to 0.
- R3: `mf_boundary` is 1 in exactly the cycles where `mf_count` is 0.
- R4: While `gen_en` is high, `sysref_out` is a one-cycle pulse repeating every MF_CLKS cycles. The first pulse appears in the cycle after the first edge that samples `gen_en` high. While `gen_en` is low, `sysref_out` is 0.
- R5: `sysref_in` is registered once and rising-edge detected. A 0-to-1 change first sampled at edge n, if honored, makes `mf_count` 0 after edge n+1. A level held high acts only once.
- R6: With `nshot_mode`=0, only the first rising edge after reset or arm restarts the counter. Later edges leave `mf_count` counting.
- R7: A one-cycle `arm` pulse clears `captured`, so the next rising edge is honored again in single-shot mode.
- R8: With `nshot_mode`=1, every rising edge of `sysref_in` restarts the counter.
- R9: `captured` rises with the first honored restart and stays high until reset or `arm`.
- R10: With `nshot_mode`=1 and `captured` high, a rising edge detected while `mf_count` is not MF_CLKS-1 sets `align_err`. The flag stays set.
- R11: `err_clr` clears `align_err` one cycle later. A new error in the same cycle wins over the clear.
- R12: With `sysref_out` looped to `sysref_in`, `align_err` stays 0 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Enables the periodic pulse generator |
| nshot_mode | input | 1 | 1 = continuous capture, 0 = single-shot |
| arm | input | 1 | Re-arms single-shot capture |
| err_clr | input | 1 | Clears the sticky alignment error |
| sysref_in | input | 1 | Reference pulse to be captured |
| sysref_out | output | 1 | Generated multiframe-period pulse |
| mf_count | output | CW | Local multiframe counter, CW = clog2(MF_CLKS) |
| mf_boundary | output | 1 | High while the counter is at 0 |
| captured | output | 1 | A restart has been honored since reset or arm |
| align_err | output | 1 | Sticky off-boundary error |

## Verification
The bench targets several corner cases, each paired with the symptom a faulty design would show:
- **Loopback:** the generated pulse is fed back to the input. A one-cycle slip in the edge pipeline or in the error compare shows up as a spurious `align_err`.
- **Late single-shot edge:** a second edge arrives off phase after capture. A design that ignores the mode restarts the counter too early.
- **Held-high level:** a design without edge detection restarts the counter on every cycle of the level.
- **Clear collision:** `err_clr` coincides with a fresh error. If the clear is given priority, the flag drops.

Random stimulus then mixes modes, arm requests, clears and generator gating against a cycle model of the requirements.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  function automatic int mf_len(int frame_octets, int frames_per_mf, int octets_per_clk);
    return (frame_octets * frames_per_mf) / octets_per_clk;
  endfunction

  function automatic int cnt_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sysref_pulse_gen.sv
module sysref_pulse_gen #(
  parameter int PERIOD = 16,
  parameter int CW     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic pulse
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= (phase == '0);
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/sysref_edge_capture.sv
module sysref_edge_capture (
  input  logic clk,
  input  logic rst,
  input  logic sysref_in,
  output logic rise
);
  logic sr_q;
  logic sr_d;

  // single input register, then one delay stage for the edge compare
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= 1'b0;
      sr_d <= 1'b0;
    end else begin
      sr_q <= sysref_in;
      sr_d <= sr_q;
    end
  end

  assign rise = sr_q & ~sr_d;
endmodule

// File: rtl/mf_counter.sv
module mf_counter #(
  parameter int LEN = 16,
  parameter int CW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [CW-1:0] count,
  output logic          boundary,
  output logic          at_last
);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  assign at_last = (count == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || at_last) begin
      count    <= '0;
      boundary <= 1'b1;
    end else begin
      count    <= count + 1'b1;
      boundary <= 1'b0;
    end
  end
endmodule

// File: rtl/mfclk_sysref_align.sv
module mfclk_sysref_align #(
  parameter int FRAME_OCTETS   = 2,
  parameter int FRAMES_PER_MF  = 32,
  parameter int OCTETS_PER_CLK = 4,
  localparam int MF_CLKS = mfa_pkg::mf_len(FRAME_OCTETS, FRAMES_PER_MF, OCTETS_PER_CLK),
  localparam int CW      = mfa_pkg::cnt_width(MF_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gen_en,
  input  logic          nshot_mode,
  input  logic          arm,
  input  logic          err_clr,
  input  logic          sysref_in,
  output logic          sysref_out,
  output logic [CW-1:0] mf_count,
  output logic          mf_boundary,
  output logic          captured,
  output logic          align_err
);
  generate
    if (((FRAME_OCTETS * FRAMES_PER_MF) % OCTETS_PER_CLK) != 0 ||
        (FRAME_OCTETS * FRAMES_PER_MF) < OCTETS_PER_CLK) begin : g_bad_cfg
      $error("multiframe length must be a whole number of link clocks, at least one");
    end
  endgenerate

  logic rise;
  logic take;
  logic off_phase;
  logic at_last;

  sysref_pulse_gen #(.PERIOD(MF_CLKS), .CW(CW)) u_gen (
    .clk   (clk),
    .rst   (rst),
    .en    (gen_en),
    .pulse (sysref_out)
  );

  sysref_edge_capture u_cap (
    .clk       (clk),
    .rst       (rst),
    .sysref_in (sysref_in),
    .rise      (rise)
  );

  // honor the edge in continuous mode, or when no capture is recorded yet
  assign take      = rise & (nshot_mode | ~captured);
  assign off_phase = rise & nshot_mode & captured & ~at_last;

  mf_counter #(.LEN(MF_CLKS), .CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .restart  (take),
    .count    (mf_count),
    .boundary (mf_boundary),
    .at_last  (at_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      captured  <= 1'b0;
      align_err <= 1'b0;
    end else begin
      captured <= arm ? 1'b0 : (captured | take);
      if (off_phase)    align_err <= 1'b1;
      else if (err_clr) align_err <= 1'b0;
    end
  end
endmodule

// File: rtl/mfa_checker.sv
module mfa_checker #(
  parameter int LEN = 16,
  parameter int CW  = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          arm,
  input logic          err_clr,
  input logic          take,
  input logic          sysref_out,
  input logic [CW-1:0] mf_count,
  input logic          mf_boundary,
  input logic          captured,
  input logic          align_err
);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  p_count_range_r2: assert property (@(posedge clk) disable iff (rst)
    mf_count <= LAST);

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!take && mf_count != LAST) |=> mf_count == $past(mf_count) + 1'b1);

  p_boundary_r3: assert property (@(posedge clk) disable iff (rst)
    mf_boundary == (mf_count == '0));

  p_pulse_width_r4: assert property (@(posedge clk) disable iff (rst)
    (LEN > 1 && sysref_out) |=> !sysref_out);

  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    take |=> mf_count == '0);

  p_captured_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (captured && !arm) |=> captured);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (align_err && !err_clr) |=> align_err);
endmodule

bind mfclk_sysref_align mfa_checker #(.LEN(MF_CLKS), .CW(CW)) u_mfa_checker (
  .clk         (clk),
  .rst         (rst),
  .arm         (arm),
  .err_clr     (err_clr),
  .take        (take),
  .sysref_out  (sysref_out),
  .mf_count    (mf_count),
  .mf_boundary (mf_boundary),
  .captured    (captured),
  .align_err   (align_err)
);

// File: tb/test_mfclk_sysref_align.sv
module test_mfclk_sysref_align;
  localparam int CLK_PERIOD = 10;
  localparam int F = 2, K = 32, W = 4;
  localparam int MFL  = (F * K) / W;
  localparam int LAST = MFL - 1;
  localparam int CW   = $clog2(MFL);

  logic clk = 1'b0;
  logic rst, gen_en, nshot_mode, arm, err_clr, sr_drv, loop;
  logic sysref_in, sysref_out, mf_boundary, captured, align_err;
  logic [CW-1:0] mf_count;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sysref_in = loop ? sysref_out : sr_drv;

  mfclk_sysref_align #(.FRAME_OCTETS(F), .FRAMES_PER_MF(K), .OCTETS_PER_CLK(W)) i_mfclk_sysref_align (
    .clk, .rst, .gen_en, .nshot_mode, .arm, .err_clr, .sysref_in,
    .sysref_out, .mf_count, .mf_boundary, .captured, .align_err
  );

  // reference model state, built from the requirements
  int m_cnt, m_gen;
  bit m_out, m_cap, m_err, m_q, m_d;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit sr_now = loop ? m_out : sr_drv;
    bit edge_seen = m_q && !m_d;
    bit honored = edge_seen && (nshot_mode || !m_cap);
    bit bad = edge_seen && nshot_mode && m_cap && (m_cnt != LAST);
    if (rst) begin
      m_cnt = 0; m_gen = 0; m_out = 0; m_cap = 0; m_err = 0; m_q = 0; m_d = 0;
    end else begin
      m_cnt = (honored || m_cnt == LAST) ? 0 : m_cnt + 1;      // R2, R5, R6, R8
      if (!gen_en) begin m_out = 0; m_gen = 0; end              // R4
      else begin m_out = (m_gen == 0); m_gen = (m_gen == LAST) ? 0 : m_gen + 1; end
      m_cap = arm ? 0 : (m_cap || honored);                     // R7, R9
      m_err = bad ? 1 : (err_clr ? 0 : m_err);                  // R10, R11
      m_d = m_q; m_q = sr_now;
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R2 mf_count", int'(mf_count), m_cnt);
    chk("R3 mf_boundary", int'(mf_boundary), int'(m_cnt == 0));
    chk("R4 sysref_out", int'(sysref_out), int'(m_out));
    chk("R9 captured", int'(captured), int'(m_cap));
    chk("R10 align_err", int'(align_err), int'(m_err));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int last_pulse, c0;
    void'($urandom(32'd2024));
    rst = 1; gen_en = 0; nshot_mode = 0; arm = 0; err_clr = 0; sr_drv = 0; loop = 0;
    @(negedge clk);
    ticks(3);
    // R1 reset state
    chk("R1 count", int'(mf_count), 0);
    chk("R1 boundary", int'(mf_boundary), 1);
    chk("R1 sysref_out", int'(sysref_out), 0);
    chk("R1 captured", int'(captured), 0);
    chk("R1 align_err", int'(align_err), 0);
    rst = 0;
    ticks(5);

    // R4 period and R12 loopback in single-shot, then continuous
    gen_en = 1; loop = 1;
    last_pulse = -1;
    for (int i = 0; i < 100; i++) begin
      if (i == 40) nshot_mode = 1;
      tick();
      if (sysref_out) begin
        if (last_pulse >= 0) chk("R4 period", i - last_pulse, MFL);
        last_pulse = i;
      end
    end
    chk("R12 no error on loopback", int'(align_err), 0);
    chk("R9 captured after loopback", int'(captured), 1);

    // R6 single-shot ignores a late off-phase edge
    nshot_mode = 0; loop = 0; gen_en = 0;
    while (mf_count != 5) tick();
    c0 = mf_count;
    sr_drv = 1; tick(); sr_drv = 0; tick();
    chk("R6 late edge ignored", int'(mf_count), (c0 + 2) % MFL);

    // R7 arm re-enables one capture
    arm = 1; tick(); arm = 0;
    chk("R7 arm clears captured", int'(captured), 0);
    while (mf_count != 7) tick();
    sr_drv = 1; tick(); sr_drv = 0; tick();
    chk("R7 restart after arm", int'(mf_count), 0);

    // R5 held level acts once; R8 continuous realign
    nshot_mode = 1;
    while (mf_count != 3) tick();
    sr_drv = 1; tick(); tick();
    chk("R8 continuous restart", int'(mf_count), 0);
    chk("R10 off-phase error", int'(align_err), 1);
    ticks(8);
    chk("R5 held level acts once", int'(mf_count), 8);
    sr_drv = 0; ticks(4);
    chk("R10 error sticky", int'(align_err), 1);

    // R11 clear, and set winning over clear
    err_clr = 1; tick(); err_clr = 0; tick();
    chk("R11 clear", int'(align_err), 0);
    while (mf_count != 4) tick();
    sr_drv = 1; tick(); sr_drv = 0;
    err_clr = 1; tick(); err_clr = 0; tick();
    chk("R11 set beats clear", int'(align_err), 1);
    err_clr = 1; tick(); err_clr = 0;

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        loop = $urandom % 2; nshot_mode = $urandom % 2; gen_en = ($urandom % 4) != 0;
      end
      sr_drv  = ($urandom % 23) == 0;
      arm     = ($urandom % 61) == 0;
      err_clr = ($urandom % 37) == 0;
      rst     = ($urandom % 997) == 0;
      tick();
    end
    rst = 0; arm = 0; err_clr = 0; sr_drv = 0;
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule